// File: doc/BRIEF.md
# Register Block Address Remapper

This block sits between instruction decode and the register file. It gives each thread or task its own private copy of the lowest registers. A small configuration word selects three things: how many low registers are private, how many copies of them exist, and where the copy number comes from. The copy number is either the low bits of an index pointer or the current task number. Two direct register address fields arrive with each instruction, one for the destination and one for the source. Whenever remapping applies to a field, the block places the copy number just above that field's offset bits. The result is a physical 9-bit register address.

A new configuration is written with a strobe that belongs to one instruction slot. Slots advance whenever `instrStep` is high. The written value stays pending until two further slots have gone by. It becomes active for the third slot after the write, so the program has room to lay out its code before the new mapping takes hold. Once a configuration is active, the copy number follows the index pointer or task number in the same cycle.

Top module: `reg_block_remap`

## Requirements
- R1: The configuration word holds three fields. Bit 6 selects the copy-number source: 0 takes the low bits of `idxLow`, 1 takes `taskId`. Bits 5:3 hold `blkLog`, the log2 of the copy count. Bits 2:0 hold `regLog`, the log2 of the private register count.
- R2: While the active `blkLog` is 0, both physical outputs equal their input addresses, whatever the other fields hold.
- R3: A direct address below 2^`regLog` is output as `(sel << regLog) | addr`, truncated to 9 bits. Here `sel` is the source value masked to its low `blkLog` bits.
- R4: In task mode the 2-bit task number is zero-extended before masking. With `blkLog`=1 only task bit 0 selects the copy.
- R5: A direct address at or above 2^`regLog` passes through unchanged.
- R6: A configuration written in one instruction slot (`cfgWrite` and `instrStep` both high) is not used in the next two slots and is used from the third slot onward. Cycles with `instrStep` low do not count as slots.
- R7: While a configuration is active, a change of `idxLow` or `taskId` changes the physical address in the same cycle.
- R8: An address field whose direct flag is low passes through unchanged.
- R9: After reset the active configuration is all zeros, so remapping is disabled.
- R10: A `cfgWrite` in a cycle with `instrStep` low is ignored.
- R11: A second write made while an earlier one is still pending replaces it and restarts the three-slot delay. The earlier value never becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrStep | input | 1 | High when the current cycle's instruction slot advances |
| cfgWrite | input | 1 | Configuration write strobe, qualified by `instrStep` |
| cfgWord | input | 7 | Configuration value {source, blkLog, regLog} |
| idxLow | input | 7 | Low bits of the index pointer |
| taskId | input | 2 | Current task number |
| dAddr | input | 9 | Destination address field |
| dDirect | input | 1 | Destination field is a hard-coded direct address |
| sAddr | input | 9 | Source address field |
| sDirect | input | 1 | Source field is a hard-coded direct address |
| dPhys | output | 9 | Physical destination register address |
| sPhys | output | 9 | Physical source register address |

## Verification
The hardest behaviour to reach is the delayed activation. Whether the old or the new configuration is in force depends on how many instruction slots, not clock cycles, have passed since the write. It also depends on whether a newer write has restarted the count. The stimulus therefore mixes cycles with `instrStep` high and low after each write, and issues back-to-back writes. It also issues strobes in non-slot cycles. On every cycle the expected addresses come from a slot-counting model in the bench. A final sweep walks every block and register count whose result fits in 9 bits.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int FIELD_W = 3;
  localparam int CFG_W   = 2 * FIELD_W + 1;

  // Active or pending remap configuration.
  typedef struct packed {
    logic               taskSel;  // 1: task number picks the copy
    logic [FIELD_W-1:0] blkLog;   // log2 of copy count, 0 disables
    logic [FIELD_W-1:0] regLog;   // log2 of private register count
  } remapCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // latch incoming word into the pending register
    logic commit;   // move pending word into the active register
  } cfgStrobe_t;

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int DELAY_SLOTS = 3  // slot index, counted from the write, where the new word applies (>= 2)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrStep,
  input  logic       cfgWrite,
  output cfgStrobe_t strobe
);

  localparam int CNT_W = $clog2(DELAY_SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_SLOTS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] slotsLeft;
  logic             captureNow;

  assign captureNow = cfgWrite & instrStep;

  always_comb begin
    strobe.capture = captureNow;
    strobe.commit  = instrStep & ~captureNow & (slotsLeft == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotsLeft <= '0;
    end else if (captureNow) begin
      slotsLeft <= CNT_LOAD;
    end else if (instrStep && slotsLeft != '0) begin
      slotsLeft <= slotsLeft - CNT_LAST;
    end
  end

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 7,
  parameter int TASK_W = 2
) (
  input  remapCfg_t         cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              direct,
  input  logic [IDX_W-1:0]  idxLow,
  input  logic [TASK_W-1:0] taskId,
  output logic [ADDR_W-1:0] phys
);

  localparam int MAX_SHIFT = (1 << FIELD_W) - 1;
  localparam int WIDE_W    = IDX_W + MAX_SHIFT;

  logic [IDX_W-1:0]  selRaw;
  logic [IDX_W-1:0]  blkMask;
  logic [IDX_W-1:0]  sel;
  logic              inRange;
  logic              applies;
  logic [ADDR_W-1:0] placed;

  always_comb begin
    selRaw  = cfg.taskSel ? IDX_W'(taskId) : idxLow;
    blkMask = IDX_W'((1 << cfg.blkLog) - 1);
    sel     = selRaw & blkMask;
    inRange = (addr >> cfg.regLog) == '0;
    applies = direct && inRange && (cfg.blkLog != '0);
    placed  = ADDR_W'(WIDE_W'(sel) << cfg.regLog);
    phys    = applies ? (placed | addr) : addr;
  end

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int IDX_W     = 7,
  parameter int TASK_W    = 2,
  parameter int NUM_PORTS = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cfgStrobe_t                       strobe,
  input  logic [CFG_W-1:0]                 cfgWord,
  input  logic [IDX_W-1:0]                 idxLow,
  input  logic [TASK_W-1:0]                taskId,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrIn,
  input  logic [NUM_PORTS-1:0]             directIn,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0] physOut,
  output remapCfg_t                        activeCfg
);

  remapCfg_t pendCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg   <= '0;
      activeCfg <= '0;
    end else begin
      if (strobe.capture) pendCfg <= remapCfg_t'(cfgWord);
      if (strobe.commit)  activeCfg <= pendCfg;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    remap_xlate #(
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W),
      .TASK_W(TASK_W)
    ) u_xlate (
      .cfg   (activeCfg),
      .addr  (addrIn[p]),
      .direct(directIn[p]),
      .idxLow(idxLow),
      .taskId(taskId),
      .phys  (physOut[p])
    );
  end

endmodule

// File: rtl/reg_block_remap.sv
module reg_block_remap
  import remap_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int IDX_W       = 7,
  parameter int TASK_W      = 2,
  parameter int DELAY_SLOTS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrStep,
  input  logic              cfgWrite,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [IDX_W-1:0]  idxLow,
  input  logic [TASK_W-1:0] taskId,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              dDirect,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic              sDirect,
  output logic [ADDR_W-1:0] dPhys,
  output logic [ADDR_W-1:0] sPhys
);

  localparam int NUM_PORTS = 2;
  localparam int PORT_D    = 0;
  localparam int PORT_S    = 1;

  cfgStrobe_t                       strobe;
  remapCfg_t                        activeCfg;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrIn;
  logic [NUM_PORTS-1:0]             directIn;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] physOut;

  always_comb begin
    addrIn[PORT_D]   = dAddr;
    addrIn[PORT_S]   = sAddr;
    directIn[PORT_D] = dDirect;
    directIn[PORT_S] = sDirect;
  end

  assign dPhys = physOut[PORT_D];
  assign sPhys = physOut[PORT_S];

  remap_ctrl #(
    .DELAY_SLOTS(DELAY_SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instrStep(instrStep),
    .cfgWrite (cfgWrite),
    .strobe   (strobe)
  );

  remap_datapath #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .TASK_W   (TASK_W),
    .NUM_PORTS(NUM_PORTS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWord  (cfgWord),
    .idxLow   (idxLow),
    .taskId   (taskId),
    .addrIn   (addrIn),
    .directIn (directIn),
    .physOut  (physOut),
    .activeCfg(activeCfg)
  );

endmodule

// File: rtl/reg_block_remap_checker.sv
module reg_block_remap_checker
  import remap_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrStep,
  input logic              cfgWrite,
  input logic [ADDR_W-1:0] dAddr,
  input logic              dDirect,
  input logic [ADDR_W-1:0] sAddr,
  input logic              sDirect,
  input logic [ADDR_W-1:0] dPhys,
  input logic [ADDR_W-1:0] sPhys,
  input remapCfg_t         activeCfg
);

  logic [ADDR_W-1:0] offMask;
  assign offMask = ADDR_W'((1 << activeCfg.regLog) - 1);

  // R2: a disabled mapping leaves both fields untouched
  a_r2_disabled_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (activeCfg.blkLog == '0) |-> (dPhys == dAddr && sPhys == sAddr));

  // R8: indirect fields bypass the remapper
  a_r8_indirect_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (!dDirect |-> dPhys == dAddr) and (!sDirect |-> sPhys == sAddr));

  // R5: addresses above the private window pass through
  a_r5_above_window: assert property (@(posedge clk) disable iff (!rstN)
    (dDirect && (dAddr >> activeCfg.regLog) != '0) |-> dPhys == dAddr);

  // R3: the offset bits inside the window are preserved
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    ((dPhys & offMask) == (dAddr & offMask)) && ((sPhys & offMask) == (sAddr & offMask)));

  // R6: the slot that writes a word does not activate anything at its edge
  a_r6_no_early_apply: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && instrStep) |=> $stable(activeCfg));

  // R6, R10: activation only happens at an instruction slot edge
  a_r6_apply_on_slot: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeCfg) |-> $past(instrStep));

  // R9: reset clears the active configuration
  a_r9_reset_clear: assert property (@(posedge clk)
    !rstN |=> activeCfg == '0);

endmodule

bind reg_block_remap reg_block_remap_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .instrStep(instrStep),
  .cfgWrite (cfgWrite),
  .dAddr    (dAddr),
  .dDirect  (dDirect),
  .sAddr    (sAddr),
  .sDirect  (sDirect),
  .dPhys    (dPhys),
  .sPhys    (sPhys),
  .activeCfg(activeCfg)
);

// File: tb/reg_block_remap_test.sv
`timescale 1ns/1ps
module reg_block_remap_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instrStep = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [6:0] cfgWord = '0;
  logic [6:0] idxLow = '0;
  logic [1:0] taskId = '0;
  logic [8:0] dAddr = '0;
  logic       dDirect = 1'b0;
  logic [8:0] sAddr = '0;
  logic       sDirect = 1'b0;
  logic [8:0] dPhys;
  logic [8:0] sPhys;

  always #4 clk = ~clk;  // 125 MHz

  reg_block_remap uut (
    .clk(clk), .rstN(rstN), .instrStep(instrStep), .cfgWrite(cfgWrite),
    .cfgWord(cfgWord), .idxLow(idxLow), .taskId(taskId),
    .dAddr(dAddr), .dDirect(dDirect), .sAddr(sAddr), .sDirect(sDirect),
    .dPhys(dPhys), .sPhys(sPhys)
  );

  typedef struct {
    int    dExp;
    int    sExp;
    string tag;
  } item_t;

  item_t expQ[$];
  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // Bench model of the configuration timing (R6, R10, R11)
  int mActive = 0;
  int mPend   = 0;
  int mLeft   = 0;

  function automatic int expect_addr(int cfg, int addr, bit dir, int idx, int tsk);
    int blk, rl, sel;
    blk = (cfg >> 3) & 7;
    rl  = cfg & 7;
    if (blk == 0 || !dir || addr >= (1 << rl)) return addr;
    sel = ((cfg >> 6) & 1) ? tsk : idx;
    sel = sel & ((1 << blk) - 1);
    return ((sel << rl) | addr) & 9'h1FF;
  endfunction

  // Driver: one call is one clock cycle.
  task automatic drive(bit step, bit wr, int word, int idx, int tsk,
                       int da, bit dd, int sa, bit sd, string tag);
    item_t it;
    @(negedge clk);
    instrStep = step; cfgWrite = wr; cfgWord = 7'(word);
    idxLow = 7'(idx); taskId = 2'(tsk);
    dAddr = 9'(da); dDirect = dd; sAddr = 9'(sa); sDirect = sd;
    it.dExp = expect_addr(mActive, da, dd, idx, tsk);
    it.sExp = expect_addr(mActive, sa, sd, idx, tsk);
    it.tag  = tag;
    expQ.push_back(it);
    if (step && wr) begin
      mPend = word; mLeft = 2;
    end else if (step && mLeft > 0) begin
      if (mLeft == 1) mActive = mPend;
      mLeft--;
    end
  endtask

  task automatic slot(int idx, int tsk, int da, bit dd, int sa, bit sd, string tag);
    drive(1'b1, 1'b0, 0, idx, tsk, da, dd, sa, sd, tag);
  endtask

  task automatic write_cfg(int word, string tag);
    drive(1'b1, 1'b1, word, 0, 0, 0, 1'b1, 1, 1'b1, tag);
  endtask

  // Monitor: compares away from the active edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        vectors++;
        if (int'(dPhys) != it.dExp || int'(sPhys) != it.sExp) begin
          misses++;
          $display("FAIL %s: dPhys=%0h sPhys=%0h expected %0h %0h",
                   it.tag, dPhys, sPhys, it.dExp, it.sExp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset leaves remapping disabled
    slot(5, 3, 0, 1, 2, 1, "R9 reset state");

    // R6, R3: 4 copies of 4 registers by index; delay counted in slots
    write_cfg(7'h12, "R6 write slot old cfg");
    slot(2, 0, 3, 1, 1, 1, "R6 slot1 old cfg");
    drive(1'b0, 1'b0, 0, 2, 0, 3, 1, 1, 1, "R6 non-slot cycle not counted");
    slot(2, 0, 3, 1, 1, 1, "R6 slot2 old cfg");
    slot(2, 0, 3, 1, 1, 1, "R3 slot3 new cfg d=11");

    // R7: selector change takes effect at once
    slot(1, 0, 3, 1, 0, 1, "R7 idx change d=7");
    slot(3, 0, 3, 1, 2, 1, "R7 idx change d=15");
    // R5 and R8
    slot(3, 0, 4, 1, 9'h1FF, 1, "R5 above window");
    slot(3, 0, 0, 0, 1, 0, "R8 indirect bypass");
    slot(3, 0, 0, 1, 1, 0, "R8 mixed direct/indirect");

    // R10: write without a slot is ignored
    drive(1'b0, 1'b1, 7'h00, 1, 0, 2, 1, 2, 1, "R10 strobe without slot");
    repeat (4) slot(1, 0, 2, 1, 3, 1, "R10 mapping unchanged");

    // R1: task mode, 4 copies of 4 registers
    write_cfg(7'h52, "R1 task write");
    repeat (2) slot(0, 3, 1, 1, 1, 1, "R1 task pending");
    slot(0, 3, 1, 1, 2, 1, "R1 task mode d=13");
    slot(2, 1, 1, 1, 3, 1, "R1 task ignores idx");

    // R4: 2-bit task zero-extended under 8 copies; 2 copies use bit 0
    write_cfg(7'h59, "R4 write 8x2");
    repeat (2) slot(0, 3, 1, 1, 0, 1, "R4 pending");
    slot(7, 3, 1, 1, 0, 1, "R4 8 copies task 3");
    write_cfg(7'h4A, "R4 write 2x4");
    repeat (2) slot(0, 3, 2, 1, 0, 1, "R4 pending");
    slot(0, 3, 2, 1, 0, 1, "R4 task bit0 only d=6");
    slot(0, 2, 2, 1, 0, 1, "R4 task 2 selects copy 0");

    // R2: blkLog 0 disables whatever the register count
    write_cfg(7'h07, "R2 write disabled");
    repeat (3) slot(7'h7F, 3, 5, 1, 7'h7F, 1, "R2 disabled passthru");

    // R11: a newer write restarts the delay and replaces the old one
    write_cfg(7'h12, "R11 first write");
    slot(1, 0, 1, 1, 2, 1, "R11 pending");
    write_cfg(7'h0A, "R11 second write");
    slot(1, 0, 1, 1, 2, 1, "R11 restart slot1");
    slot(1, 0, 1, 1, 2, 1, "R11 restart slot2 still disabled");
    slot(1, 0, 1, 1, 2, 1, "R11 second value active");

    // R3 sweep: every combination that fits in 9 bits
    for (int blk = 1; blk < 8; blk++) begin
      for (int rl = 0; rl < 8; rl++) begin
        if (blk + rl <= 9) begin
          write_cfg((blk << 3) | rl, "R3 sweep write");
          slot(0, 0, 0, 1, 0, 1, "R3 sweep pending");
          slot(0, 0, 0, 1, 0, 1, "R3 sweep pending");
          for (int k = 0; k < 4; k++) begin
            int idx, a;
            idx = (k * 37 + blk * 11 + rl) & 7'h7F;
            a   = (k * 5 + rl) & ((1 << rl) - 1);
            slot(idx, k, a, 1, (1 << rl), 1, "R3 sweep");
          end
        end
      end
    end

    // large corners
    write_cfg(7'h3A, "R3 corner write");
    repeat (2) slot(0, 0, 0, 1, 0, 1, "R3 corner pending");
    slot(7'h7F, 0, 2, 1, 3, 1, "R3 128x4 top copy");
    write_cfg(7'h0F, "R3 corner write");
    repeat (2) slot(0, 0, 0, 1, 0, 1, "R3 corner pending");
    slot(1, 0, 9'h45, 1, 9'h7F, 1, "R3 2x128 upper copy");

    repeat (2) @(negedge clk);
    #5;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule